// File: doc/BRIEF.md
# Clock Divider Ratio Generator

This block takes one fast input clock and produces three clock-enable strobes, one each for the processor core, the system bus and the peripheral domain. Every strobe is a one-cycle pulse in the input clock domain, repeating once every N input cycles. N is an integer ratio chosen by a 3-bit code in a 16-bit control register. No clock is gated or generated. Logic in each domain stays on the fast clock and qualifies its registers with the matching strobe.

The core and bus codes share one ratio table. The peripheral code uses a second, separate table. Both tables include ratios that are not powers of two (3, 5 and 6). Codes with no defined meaning fall back to the slowest ratio, divide-by-8.

Software writes the control register through a single-cycle write strobe and reads it back at all times. A write restarts all three divider counters, so the new ratios start from a clean phase boundary. When a write changes the peripheral code, a one-cycle notification pulse is raised so that dependent blocks can recompute their timing.

Top module: `clkratio_gen`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x0E0A. This selects core ratio 1, bus ratio 2 and peripheral ratio 4, and the enables run at those rates.
- R2: The core code is register bits 8:6. Codes 0..7 give ratios 1, 2, 3, 4, 5, 8, 8, 8.
- R3: The bus code is register bits 5:3. It uses the same mapping as the core code: 1, 2, 3, 4, 5, 8, 8, 8.
- R4: The peripheral code is register bits 2:0. Codes 0..7 give ratios 2, 3, 4, 6, 8, 8, 8, 8.
- R5: Reserved codes give divide-by-8. For the core and bus codes these are 6 and 7. For the peripheral code they are 5, 6 and 7.
- R6: An enable with ratio N is high for exactly one cycle in every N cycles. With ratio 1 the enable stays high continuously.
- R7: A write restarts every divider. Count the cycle after the write edge as cycle 1. Each enable then pulses first in cycle N, and again in every later multiple of N.
- R8: All 16 written bits appear on `cfg_rdata` from the cycle after the write edge. This includes bits 15:9, which are stored but have no effect.
- R9: `per_ratio_chg` is high for exactly the one cycle after a write that changes bits 2:0. It stays low after a write that leaves bits 2:0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 16 | Value to write |
| cfg_rdata | output | 16 | Current control register value |
| core_en | output | 1 | Core-domain clock enable |
| bus_en | output | 1 | Bus-domain clock enable |
| per_en | output | 1 | Peripheral-domain clock enable |
| per_ratio_chg | output | 1 | One-cycle pulse after a write that changes the peripheral code |

## Verification
The embedded properties check the following on every cycle:
- No divider counter ever reaches its ratio.
- Once an enable pulses with a ratio above 1, it goes low again in the next cycle.
- A ratio of 1 keeps its enable high.
- A restart leaves each enable in the state its new ratio implies.
- Readback follows the written word.
- The change pulse only ever follows a write.

Some properties can only be shown by the bench's scenarios. These are:
- Each code maps to the correct ratio, including the reserved codes.
- A pulse falls exactly in cycle N after a write.
- A write that keeps the peripheral code produces no change pulse.
- The reset configuration produces the expected pulse counts over a whole window.

// File: rtl/clkratio_pkg.sv
package clkratio_pkg;

  localparam int CR_W    = 16;
  localparam int FLD_W   = 3;
  localparam int RATIO_W = 4;
  localparam int NUM_DOM = 3;

  // field positions are decoded by the dividers, so they are fixed
  localparam int CORE_LSB = 6;
  localparam int BUS_LSB  = 3;
  localparam int PER_LSB  = 0;

  localparam logic [CR_W-1:0] CR_RESET = 16'h0E0A;

  typedef logic [FLD_W-1:0]   code_t;
  typedef logic [RATIO_W-1:0] ratio_t;

  typedef enum logic [1:0] {
    DOM_CORE = 2'd0,
    DOM_BUS  = 2'd1,
    DOM_PER  = 2'd2
  } dom_e;

  // core and bus table; reserved codes clamp to 8
  function automatic ratio_t core_ratio(code_t code);
    ratio_t r;
    case (code)
      3'd0:    r = ratio_t'(1);
      3'd1:    r = ratio_t'(2);
      3'd2:    r = ratio_t'(3);
      3'd3:    r = ratio_t'(4);
      3'd4:    r = ratio_t'(5);
      default: r = ratio_t'(8);
    endcase
    return r;
  endfunction

  // peripheral table; reserved codes clamp to 8
  function automatic ratio_t periph_ratio(code_t code);
    ratio_t r;
    case (code)
      3'd0:    r = ratio_t'(2);
      3'd1:    r = ratio_t'(3);
      3'd2:    r = ratio_t'(4);
      3'd3:    r = ratio_t'(6);
      default: r = ratio_t'(8);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/clkratio_rst_sync.sv
module clkratio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/clkratio_ctrl_reg.sv
module clkratio_ctrl_reg
  import clkratio_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CR_W-1:0] wr_data,
  output logic [CR_W-1:0] cr_q,
  output logic            per_chg
);

  logic [CR_W-1:0] cr_d;
  logic            per_chg_d;
  logic            per_diff;

  always_comb begin
    per_diff  = wr_data[PER_LSB +: FLD_W] != cr_q[PER_LSB +: FLD_W];
    cr_d      = wr_en ? wr_data : cr_q;
    per_chg_d = wr_en && per_diff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_q    <= CR_RESET;
      per_chg <= 1'b0;
    end else begin
      cr_q    <= cr_d;
      per_chg <= per_chg_d;
    end
  end

  AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cr_q == $past(wr_data)));  // R8

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cr_q));  // R8

  AST_CHG_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    per_chg |-> $past(wr_en));  // R9

  AST_CHG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (per_chg && !wr_en) |=> !per_chg);  // R9

endmodule

// File: rtl/clkratio_div.sv
module clkratio_div #(
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [RATIO_W-1:0] ratio,
  output logic               en_o
);

  localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] cnt_d;
  logic [RATIO_W-1:0] last_cnt;
  logic               at_end;

  always_comb begin
    last_cnt = ratio - ONE;
    at_end   = cnt_q >= last_cnt;
    if (restart) begin
      cnt_d = '0;
    end else if (at_end) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign en_o = (cnt_q == last_cnt);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio);  // R6

  AST_PULSE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && (ratio != ONE) && !restart) |=> !en_o);  // R6

  AST_UNITY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio == ONE) |-> en_o);  // R6

  AST_RESTART_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (en_o == (ratio == ONE)));  // R7

endmodule

// File: rtl/clkratio_gen.sv
module clkratio_gen
  import clkratio_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [CR_W-1:0] cfg_wdata,
  output logic [CR_W-1:0] cfg_rdata,
  output logic            core_en,
  output logic            bus_en,
  output logic            per_en,
  output logic            per_ratio_chg
);

  logic                rst_n_s;
  logic [CR_W-1:0]     cr_q;
  ratio_t              ratio_vec [NUM_DOM];
  logic [NUM_DOM-1:0]  en_vec;

  clkratio_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  clkratio_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .cr_q    (cr_q),
    .per_chg (per_ratio_chg)
  );

  always_comb begin
    ratio_vec[DOM_CORE] = core_ratio(cr_q[CORE_LSB +: FLD_W]);
    ratio_vec[DOM_BUS]  = core_ratio(cr_q[BUS_LSB +: FLD_W]);
    ratio_vec[DOM_PER]  = periph_ratio(cr_q[PER_LSB +: FLD_W]);
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_div
    clkratio_div #(.RATIO_W(RATIO_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .restart (cfg_we),
      .ratio   (ratio_vec[d]),
      .en_o    (en_vec[d])
    );
  end

  assign cfg_rdata = cr_q;
  assign core_en   = en_vec[DOM_CORE];
  assign bus_en    = en_vec[DOM_BUS];
  assign per_en    = en_vec[DOM_PER];

  AST_RESERVED_SLOWEST: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cr_q[CORE_LSB +: FLD_W] >= 3'd5 && !$past(cfg_we) && core_en) |=> !core_en);  // R5

endmodule

// File: tb/clkratio_gen_bench.sv
module clkratio_gen_bench;

  localparam int WIN = 120;

  typedef struct {
    logic [15:0] val;
    int          n_core;
    int          n_bus;
    int          n_per;
    bit          chg;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        core_en, bus_en, per_en, per_ratio_chg;

  int total = 0;
  int bad = 0;
  int pushed = 0;
  int popped = 0;
  int done_cnt = 0;
  bit finished = 1'b0;
  logic [15:0] last_val = 16'h0E0A;
  item_t sb_q[$];

  always #10 clk = ~clk;

  clkratio_gen u_clkratio_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_wdata     (cfg_wdata),
    .cfg_rdata     (cfg_rdata),
    .core_en       (core_en),
    .bus_en        (bus_en),
    .per_en        (per_en),
    .per_ratio_chg (per_ratio_chg)
  );

  function automatic int exp_core(int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 3;
      3: return 4;
      4: return 5;
      default: return 8;
    endcase
  endfunction

  function automatic int exp_per(int code);
    case (code)
      0: return 2;
      1: return 3;
      2: return 4;
      3: return 6;
      default: return 8;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // driver: write the register and push the expected behaviour
  task automatic write_cfg(logic [15:0] v, string tag);
    item_t it;
    it.val    = v;
    it.n_core = exp_core(int'(v[8:6]));
    it.n_bus  = exp_core(int'(v[5:3]));
    it.n_per  = exp_per(int'(v[2:0]));
    it.chg    = (v[2:0] != last_val[2:0]);
    it.tag    = tag;
    last_val  = v;
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = v;
    sb_q.push_back(it);
    pushed++;
    @(negedge clk);
    cfg_we = 1'b0;
    wait (done_cnt == pushed);
  endtask

  // monitor: per-cycle comparison over one window after each write
  initial begin
    forever begin
      item_t it;
      int mis_c, mis_b, mis_p;
      int fc, fb, fp;
      wait (pushed > popped);
      it = sb_q.pop_front();
      popped++;
      mis_c = 0; mis_b = 0; mis_p = 0;
      fc = 0; fb = 0; fp = 0;
      @(negedge clk);
      for (int k = 1; k <= WIN; k++) begin
        if (k > 1) @(negedge clk);
        if (k == 1) begin
          chk(cfg_rdata == it.val, "R8", {it.tag, " readback"}, int'(cfg_rdata), int'(it.val));
          chk(per_ratio_chg == it.chg, "R9", {it.tag, " change pulse"}, int'(per_ratio_chg), int'(it.chg));
        end
        if (k == 2) begin
          chk(per_ratio_chg == 1'b0, "R9", {it.tag, " pulse one cycle"}, int'(per_ratio_chg), 0);
        end
        if (core_en != ((k % it.n_core) == 0)) begin
          if (mis_c == 0) fc = k;
          mis_c++;
        end
        if (bus_en != ((k % it.n_bus) == 0)) begin
          if (mis_b == 0) fb = k;
          mis_b++;
        end
        if (per_en != ((k % it.n_per) == 0)) begin
          if (mis_p == 0) fp = k;
          mis_p++;
        end
      end
      // R2 R6 R7: core pattern; act = first mismatching cycle, exp = ratio
      chk(mis_c == 0, "R2/R6/R7", {it.tag, " core_en pattern"}, fc, it.n_core);
      // R3 R6 R7: bus pattern
      chk(mis_b == 0, "R3/R6/R7", {it.tag, " bus_en pattern"}, fb, it.n_bus);
      // R4 R6 R7: peripheral pattern
      chk(mis_p == 0, "R4/R6/R7", {it.tag, " per_en pattern"}, fp, it.n_per);
      done_cnt++;
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL R7 watchdog expired act=%0d exp=%0d", done_cnt, pushed);
    finish_run();
  end

  initial begin
    int cc, bc, pc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state and reset rates, counted over a full window
    chk(cfg_rdata == 16'h0E0A, "R1", "reset value", int'(cfg_rdata), 16'h0E0A);
    chk(per_ratio_chg == 1'b0, "R9", "no pulse out of reset", int'(per_ratio_chg), 0);
    cc = 0; bc = 0; pc = 0;
    for (int k = 0; k < WIN; k++) begin
      cc += int'(core_en);
      bc += int'(bus_en);
      pc += int'(per_en);
      @(negedge clk);
    end
    chk(cc == WIN,     "R1", "reset core pulses", cc, WIN);
    chk(bc == WIN / 2, "R1", "reset bus pulses",  bc, WIN / 2);
    chk(pc == WIN / 4, "R1", "reset per pulses",  pc, WIN / 4);

    write_cfg(16'h0E0A, "R9 same code rewrite");
    write_cfg(16'h00A3, "R2 R3 R4 odd ratios 3/5/6");
    write_cfg(16'h00C9, "R2 R3 R4 ratios 4/2/3");
    write_cfg(16'h01BD, "R5 reserved 6/7/5");
    write_cfg(16'h01EF, "R5 reserved 7/5/7");
    write_cfg(16'hF040, "R8 upper bits stored");
    write_cfg(16'hF080, "R9 core-only change");
    write_cfg(16'h0126, "R5 core 4 bus 4 per 6");

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule